// File: doc/BRIEF.md
# DAC Sample-Rate Phase Accumulator

This block sets the output sample rate of a stereo audio converter. A 26-bit phase accumulator grows by a programmable 20-bit frequency word once in every four clocks. Each time the sum carries out of the accumulator's top bit, the block captures the current left and right PCM register values as the next sample pair for the converter. In the same cycle it raises a one-clock sample-request interrupt, so software can refill the PCM registers before the next carry.

Four 16-bit registers sit on a simple word-addressed read/write port. Two registers hold the frequency word and two hold the channel samples. The low 16 bits of the frequency word come from one register, and the low nibble of a second register supplies the top 4 bits. The upper 12 bits of that second register can be stored and read back, but they never enter the sum. The fractional remainder stays in the accumulator after a carry, so the mean sample rate is exactly word / 2^26 of the update rate.

Top module: `dac_rate_gen`

## Requirements
- R1: After reset, all four registers read 0, `pcm_left`, `pcm_right`, `pcm_valid` and `sample_irq` are 0, and the accumulator and prescaler hold 0.
- R2: Register addresses: 0 = frequency low 16 bits, 1 = frequency high (bits 3:0 used), 2 = left PCM, 3 = right PCM. A write with `bus_we` high takes effect on the rising edge. `bus_rdata` shows the addressed register combinationally, and all 16 bits are stored.
- R3: The accumulator changes only on every fourth rising edge after reset is released (the 4th, 8th, 12th edge and so on). With a word of 0x80000, valid pulses are exactly 512 clocks apart.
- R4: The increment is {reg1[3:0], reg0}. Bits 15:4 of register 1 have no effect on the rate.
- R5: An overflow is the carry out of bit 25 of accumulator + increment. The accumulator keeps the wrapped 26-bit remainder, so after N updates from value S the pulse count is floor((S + N·word) / 2^26).
- R6: On an overflow edge, `pcm_left`/`pcm_right` load registers 2 and 3, and `pcm_valid` and `sample_irq` are both high for exactly that one following cycle. Between overflows the outputs hold their values.
- R7: With a frequency word of zero, no valid pulse or interrupt ever occurs.
- R8: A register write on the same edge as an overflow does not change the pair latched on that overflow, and a new frequency word first applies at the next update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write enable |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of addressed register |
| pcm_left | output | 16 | Latched left sample |
| pcm_right | output | 16 | Latched right sample |
| pcm_valid | output | 1 | One-cycle strobe on a new sample pair |
| sample_irq | output | 1 | One-cycle sample-request interrupt |

## Verification
A wrong accumulator value or a wrong prescaler phase shows up at the ports only as a shifted valid pulse. The error may stay hidden for up to 2^26 / word updates, so the bench measures exact pulse spacing and compares every cycle against an independent model over long runs. A bad latch or capture ordering shows up on the first pulse as a wrong sample pair. Register-file faults show up at once on `bus_rdata`.

// File: rtl/dac_rate_pkg.sv
package dac_rate_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned HI_W   = 4;
  localparam int unsigned ACC_W  = 26;
  localparam int unsigned PRE_W  = 2;
  localparam int unsigned NREGS  = 4;
  localparam int unsigned ADDR_W = $clog2(NREGS);

  typedef enum logic [ADDR_W-1:0] {
    RA_FREQ_LO = 2'd0,
    RA_FREQ_HI = 2'd1,
    RA_LEFT    = 2'd2,
    RA_RIGHT   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/dac_rate_regs.sv
module dac_rate_regs
  import dac_rate_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned HW = HI_W,
  parameter int unsigned NR = NREGS,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW+HW-1:0] freq_word,
  output logic [DW-1:0] left_val,
  output logic [DW-1:0] right_val
);
  localparam int unsigned WW = DW + HW;

  function automatic logic [WW-1:0] join_word(input logic [DW-1:0] lo,
                                              input logic [DW-1:0] hi);
    return {hi[HW-1:0], lo};
  endfunction

  logic [DW-1:0] regs [NR];

  for (genvar g = 0; g < NR; g++) begin : g_reg
    logic hit;
    assign hit = we && (addr == AW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)   regs[g] <= '0;
      else if (hit) regs[g] <= wdata;
    end
  end

  assign rdata     = regs[addr];
  assign freq_word = join_word(regs[RA_FREQ_LO], regs[RA_FREQ_HI]);
  assign left_val  = regs[RA_LEFT];
  assign right_val = regs[RA_RIGHT];

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (regs[$past(addr)] == $past(wdata)));
  p_no_write_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(left_val) && $stable(right_val) && $stable(freq_word));
endmodule

// File: rtl/dac_rate_prescale.sv
module dac_rate_prescale
  import dac_rate_pkg::*;
#(
  parameter int unsigned PW = PRE_W
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == {PW{1'b1}});

  p_tick_spaced_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/dac_rate_accum.sv
module dac_rate_accum
  import dac_rate_pkg::*;
#(
  parameter int unsigned AW = ACC_W,
  parameter int unsigned IW = DATA_W + HI_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [IW-1:0] inc,
  output logic          ovf
);
  logic [AW-1:0] acc;
  logic [AW:0]   sum;

  function automatic logic [AW:0] phase_add(input logic [AW-1:0] a,
                                            input logic [IW-1:0] b);
    return {1'b0, a} + {{(AW+1-IW){1'b0}}, b};
  endfunction

  assign sum = phase_add(acc, inc);
  assign ovf = tick && sum[AW];

  always_ff @(posedge clk) begin
    if (!rst_n)    acc <= '0;
    else if (tick) acc <= sum[AW-1:0];
  end

  p_hold_between_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(acc));
  p_ovf_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> tick);
  p_zero_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc == '0) |-> !ovf);
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (acc < $past(acc)));
endmodule

// File: rtl/dac_rate_latch.sv
module dac_rate_latch
  import dac_rate_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ovf,
  input  logic [DW-1:0] left_in,
  input  logic [DW-1:0] right_in,
  output logic [DW-1:0] left_out,
  output logic [DW-1:0] right_out,
  output logic          valid,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_out  <= '0;
      right_out <= '0;
    end else if (ovf) begin
      left_out  <= left_in;
      right_out <= right_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= ovf;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= ovf;
  end

  p_irq_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq == valid);
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  p_hold_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf |=> $stable(left_out) && $stable(right_out));
  p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (left_out == $past(left_in)) && (right_out == $past(right_in)));
endmodule

// File: rtl/dac_rate_gen.sv
module dac_rate_gen
  import dac_rate_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned HW = HI_W,
  parameter int unsigned AW = ACC_W,
  parameter int unsigned PW = PRE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] pcm_left,
  output logic [DW-1:0] pcm_right,
  output logic          pcm_valid,
  output logic          sample_irq
);
  localparam int unsigned IW = DW + HW;

  logic [IW-1:0] freq_word;
  logic [DW-1:0] left_val, right_val;
  logic          tick, ovf;

  dac_rate_regs #(.DW(DW), .HW(HW), .NR(NREGS), .AW(2)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .freq_word(freq_word),
    .left_val(left_val), .right_val(right_val));

  dac_rate_prescale #(.PW(PW)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  dac_rate_accum #(.AW(AW), .IW(IW)) u_acc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .inc(freq_word), .ovf(ovf));

  dac_rate_latch #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .ovf(ovf), .left_in(left_val),
    .right_in(right_val), .left_out(pcm_left), .right_out(pcm_right),
    .valid(pcm_valid), .irq(sample_irq));

  p_pulse_needs_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid |-> $past(tick));
endmodule

// File: tb/test_dac_rate_gen.sv
`timescale 1ns/1ps
module test_dac_rate_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata, pcm_left, pcm_right;
  logic        pcm_valid, sample_irq;

  always #2.5 clk = ~clk;

  dac_rate_gen i_dac_rate_gen (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pcm_left(pcm_left),
    .pcm_right(pcm_right), .pcm_valid(pcm_valid), .sample_irq(sample_irq));

  int total = 0, bad = 0;
  bit done = 0;
  logic [15:0] m_reg [4];
  logic [25:0] m_acc;
  int          m_phase;
  logic        e_valid;
  logic [15:0] e_left, e_right;
  longint      cyc_no = 0;

  function automatic logic [19:0] word_of(input logic [15:0] lo, input logic [15:0] hi);
    return (20'(hi & 16'h000F) << 16) | 20'(lo);
  endfunction

  function automatic bit carries(input logic [25:0] a, input logic [19:0] w);
    longint s = longint'(a) + longint'(w);
    return s >= 64'd67108864;
  endfunction

  function automatic bit next_edge_ovf();
    return (m_phase == 3) && carries(m_acc, word_of(m_reg[0], m_reg[1]));
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit we, input logic [1:0] a, input logic [15:0] d);
    bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    cyc_no++;
    e_valid = 1'b0;
    if (m_phase == 3) begin
      if (carries(m_acc, word_of(m_reg[0], m_reg[1]))) begin
        e_valid = 1'b1; e_left = m_reg[2]; e_right = m_reg[3];
      end
      m_acc = 26'(longint'(m_acc) + longint'(word_of(m_reg[0], m_reg[1])));
    end
    m_phase = (m_phase + 1) % 4;
    if (we) m_reg[a] = d;
    @(negedge clk);
    check("R6", "valid", pcm_valid, e_valid);
    check("R6", "irq", sample_irq, e_valid);
    check("R6", "left", pcm_left, e_left);
    check("R6", "right", pcm_right, e_right);
    check("R2", "rdata", bus_rdata, m_reg[a]);
    bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'(i), 16'h0);
  endtask

  task automatic gap_of(output longint g);
    longint t0;
    while (!e_valid) step(1'b0, 2'd0, 16'h0);
    t0 = cyc_no;
    step(1'b0, 2'd0, 16'h0);
    while (!pcm_valid) step(1'b0, 2'd0, 16'h0);
    g = cyc_no - t0;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    longint g, pulses, exp_p, s0;
    for (int i = 0; i < 4; i++) m_reg[i] = '0;
    m_acc = '0; m_phase = 0; e_valid = 0; e_left = '0; e_right = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", "valid", pcm_valid, 0);
    check("R1", "irq", sample_irq, 0);
    check("R1", "left", pcm_left, 0);
    check("R1", "right", pcm_right, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      bus_addr = 2'(i); #0.1;
      check("R1", "reg reset", bus_rdata, 0);
    end
    // R2: write and read back every register
    step(1, 2'd2, 16'hA5C3); step(1, 2'd3, 16'h3C5A);
    step(1, 2'd1, 16'hFFF0); step(1, 2'd0, 16'h0000);
    step(0, 2'd1, 0);
    check("R2", "hi readback", bus_rdata, 16'hFFF0);
    // R7 and R4: upper bits only, word is zero
    pulses = 0;
    for (int i = 0; i < 600; i++) begin step(0, 2'd0, 0); if (pcm_valid) pulses++; end
    check("R7", "pulses at zero word", pulses, 0);
    // R3: word 0x80000 gives 512-clock spacing
    step(1, 2'd1, 16'h0008);
    gap_of(g); gap_of(g);
    check("R3", "gap word 0x80000", g, 512);
    // R4: upper bits of reg1 ignored
    step(1, 2'd1, 16'hFFF8);
    gap_of(g); gap_of(g);
    check("R4", "gap with upper bits set", g, 512);
    // R5: remainder kept, pulse count over 1024 updates
    step(1, 2'd1, 16'h000C); step(1, 2'd0, 16'h0000);
    while (m_phase != 0) step(0, 2'd0, 0);
    s0 = m_acc; pulses = 0;
    for (int i = 0; i < 4096; i++) begin step(0, 2'd0, 0); if (pcm_valid) pulses++; end
    exp_p = (s0 + 1024 * 64'h0C0000) >> 26;
    check("R5", "pulse count", pulses, exp_p);
    // R8: write on overflow edge
    step(1, 2'd1, 16'h000F); step(1, 2'd0, 16'hFFFF); step(1, 2'd2, 16'h1111);
    while (!next_edge_ovf()) step(0, 2'd0, 0);
    step(1, 2'd2, 16'h2222);
    check("R8", "left on write edge", pcm_left, 16'h1111);
    while (!next_edge_ovf()) step(0, 2'd0, 0);
    step(1, 2'd1, 16'h0001);
    check("R8", "valid on freq write edge", pcm_valid, 1);
    while (!pcm_valid) step(0, 2'd0, 0);
    check("R8", "left next pulse", pcm_left, 16'h2222);
    // random traffic, every cycle compared against the model
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 40000; i++) begin
      logic [1:0] a = 2'($urandom_range(0, 3));
      logic [15:0] d = 16'($urandom);
      if (a == 2'd1 && ($urandom_range(0, 3) != 0)) d[3:0] = 4'hF;
      step(($urandom_range(0, 7) == 0), a, d);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule